// File: doc/BRIEF.md
# USB Clock Request Power Manager

This block decides, cycle by cycle, which clocks of a USB host/device controller must keep running, so that idle clocks can be gated off to save power. It watches DMA access strobes from the device and host engines, the host's functional state, bus resume and disconnect detection, a 1 kHz frame tick and software clock-enable bits. From these it produces per-domain clock-run enables that drive external gating cells. It also produces an aggregate "USB needs a clock" flag, registered clock-on status bits, and a registered wake request for a chip in power-down.

Each DMA engine owns a retriggerable hold timer. A memory access raises that engine's clock request at once. The request then stays high until two frame ticks have passed with no further access. The host core request follows the host state: it stays high outside suspend, and inside suspend it is raised only by bus resume or disconnect activity. A domain's clock runs while its software bit is set or its hardware request is active. Software can therefore drop its enable during normal operation and leave the hardware requests to keep the clock alive.

Top module: `usb_clkreq_mgr`

## Requirements
- R1: While reset is held, all clock requests, all clock-on status bits and `wake_req` are low. With software enables clear and the host in suspend with no bus events, `usb_need_clk` is also low.
- R2: A high `dev_dma_stb` drives `dev_dma_clk_req` high in the same cycle. A high `host_dma_stb` does the same for `host_dma_clk_req`. Each engine's strobe affects only its own request.
- R3: After the last strobe, a DMA request stays high until the second frame tick has been sampled, and it is low from the cycle after that tick. A strobe in the same cycle as a tick reloads the full two-tick hold.
- R4: A new strobe while a hold is running restarts the hold from two ticks.
- R5: `host_state` encoding: 0 reset, 1 resume, 2 operational, 3 suspend. For codes 0, 1 and 2, `host_core_clk_req` is high.
- R6: With `host_state` at 3, `host_core_clk_req` is high only while `bus_resume_det` or `bus_disc_det` is high.
- R7: `dom_clk_run` bit 0 (device core) equals `sw_clk_en[0]`. Bit 1 (host core) is `sw_clk_en[1]` OR the host core request. Bit 2 (bus master) is `sw_clk_en[2]` OR either DMA request. Clearing a software bit does not stop a clock whose hardware request is active.
- R8: `usb_need_clk` is, in the same cycle, the OR of all software enables and all hardware requests.
- R9: `clk_on_sts[i]` follows `dom_clk_run[i]` one clock later, both when it rises and when it falls.
- R10: `wake_req` is high in the cycle after a cycle in which `chip_pwr_down`, `usb_int_en` and `usb_need_clk` are all high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_dma_stb | input | 1 | Device engine DMA memory access strobe |
| host_dma_stb | input | 1 | Host engine DMA memory access strobe |
| host_state | input | 2 | Host functional state (0 reset, 1 resume, 2 operational, 3 suspend) |
| bus_resume_det | input | 1 | Resume signalling detected on the bus |
| bus_disc_det | input | 1 | Disconnect detected on the bus |
| frame_tick | input | 1 | One-cycle pulse per 1 ms frame |
| sw_clk_en | input | 3 | Software clock enables: bit 0 device, bit 1 host, bit 2 bus master |
| usb_int_en | input | 1 | USB activity interrupt enable |
| chip_pwr_down | input | 1 | Chip is in power-down mode |
| dev_dma_clk_req | output | 1 | Device DMA clock request |
| host_dma_clk_req | output | 1 | Host DMA clock request |
| host_core_clk_req | output | 1 | Host core clock request |
| dom_clk_run | output | 3 | Per-domain gating enables |
| usb_need_clk | output | 1 | Aggregate clock need flag |
| clk_on_sts | output | 3 | Registered clock-on status per domain |
| wake_req | output | 1 | Registered wake request for power-down exit |

## Verification
The requests, the domain enables and `usb_need_clk` are combinational in the inputs and the hold counters, so they are due in the same cycle as the stimulus. The hold expiry, `clk_on_sts` and `wake_req` pass through one register, so they are due one cycle later. The driver applies stimulus at a falling edge and tags each expected item with the cycle it is due in, either zero or one cycles later. The monitor compares each item only in that cycle, shortly after the falling edge. Any item left in the queue past its due cycle counts as a failure.

// File: rtl/usb_clkreq_pkg.sv
package usb_clkreq_pkg;

   typedef enum logic [1:0] {
      HST_RESET   = 2'd0,
      HST_RESUME  = 2'd1,
      HST_OPER    = 2'd2,
      HST_SUSPEND = 2'd3
   } host_fstate_e;

   localparam int DOM_DEV  = 0;
   localparam int DOM_HOST = 1;
   localparam int DOM_BUS  = 2;
   localparam int NUM_DOM  = 3;

   localparam int DMA_DEV  = 0;
   localparam int DMA_HOST = 1;
   localparam int NUM_DMA  = 2;

endpackage

// File: rtl/usb_dma_hold_timer.sv
module usb_dma_hold_timer #(
   parameter int HOLD_FRAMES   = 2,
   parameter bit IMMEDIATE_REQ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic access_stb,
   input  logic frame_tick,
   output logic hold_req
);

   localparam int CNT_W = (HOLD_FRAMES < 2) ? 1 : $clog2(HOLD_FRAMES + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_FRAMES);
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   if (HOLD_FRAMES < 1) begin : g_bad_hold
      $error("usb_dma_hold_timer: HOLD_FRAMES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             hold_active;

   // reload on access wins over a coincident frame tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (access_stb) begin
         cnt_q <= RELOAD;
      end else if (frame_tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign hold_active = (cnt_q != '0);

   if (IMMEDIATE_REQ) begin : g_immediate
      assign hold_req = hold_active | access_stb;
   end else begin : g_registered
      assign hold_req = hold_active;
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);

   // R4
   hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_stb |=> hold_active);

   // R3
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active) |-> ($past(frame_tick) && !$past(access_stb)));

endmodule

// File: rtl/usb_host_core_req.sv
module usb_host_core_req
   import usb_clkreq_pkg::*;
#(
   parameter bit WAKE_ON_DISC = 1'b1
) (
   input  logic [1:0] host_state,
   input  logic       resume_det,
   input  logic       disc_det,
   output logic       core_req
);

   host_fstate_e st;
   logic         bus_event;

   assign st = host_fstate_e'(host_state);

   if (WAKE_ON_DISC) begin : g_disc
      assign bus_event = resume_det | disc_det;
   end else begin : g_no_disc
      logic unused_disc;
      assign unused_disc = disc_det;
      assign bus_event   = resume_det;
   end

   assign core_req = (st != HST_SUSPEND) | bus_event;

endmodule

// File: rtl/usb_clk_domain_ctl.sv
module usb_clk_domain_ctl #(
   parameter int STS_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_en,
   input  logic hw_req,
   output logic clk_run,
   output logic clk_on
);

   if (STS_STAGES < 1) begin : g_bad_sts
      $error("usb_clk_domain_ctl: STS_STAGES must be at least 1");
   end

   assign clk_run = sw_en | hw_req;

   if (STS_STAGES == 1) begin : g_one
      logic sts_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q <= 1'b0;
         else        sts_q <= clk_run;
      end
      assign clk_on = sts_q;

      // R9
      sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(clk_on) |-> $past(clk_run));

      // R9
      sts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(clk_on) |-> !$past(clk_run));
   end else begin : g_chain
      logic [STS_STAGES-1:0] sts_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_pipe <= '0;
         else        sts_pipe <= {sts_pipe[STS_STAGES-2:0], clk_run};
      end
      assign clk_on = sts_pipe[STS_STAGES-1];
   end

endmodule

// File: rtl/usb_clkreq_mgr.sv
module usb_clkreq_mgr
   import usb_clkreq_pkg::*;
#(
   parameter int HOLD_FRAMES  = 2,
   parameter int STS_STAGES   = 1,
   parameter bit WAKE_ON_DISC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_dma_stb,
   input  logic       host_dma_stb,
   input  logic [1:0] host_state,
   input  logic       bus_resume_det,
   input  logic       bus_disc_det,
   input  logic       frame_tick,
   input  logic [2:0] sw_clk_en,
   input  logic       usb_int_en,
   input  logic       chip_pwr_down,
   output logic       dev_dma_clk_req,
   output logic       host_dma_clk_req,
   output logic       host_core_clk_req,
   output logic [2:0] dom_clk_run,
   output logic       usb_need_clk,
   output logic [2:0] clk_on_sts,
   output logic       wake_req
);

   logic [NUM_DMA-1:0] dma_stb;
   logic [NUM_DMA-1:0] dma_req;
   logic [NUM_DOM-1:0] hw_req;
   logic               core_req;
   logic               wake_q;

   assign dma_stb[DMA_DEV]  = dev_dma_stb;
   assign dma_stb[DMA_HOST] = host_dma_stb;

   for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
      usb_dma_hold_timer #(
         .HOLD_FRAMES   (HOLD_FRAMES),
         .IMMEDIATE_REQ (1'b1)
      ) i_hold (
         .clk        (clk),
         .rst_n      (rst_n),
         .access_stb (dma_stb[g]),
         .frame_tick (frame_tick),
         .hold_req   (dma_req[g])
      );
   end

   usb_host_core_req #(
      .WAKE_ON_DISC (WAKE_ON_DISC)
   ) i_core (
      .host_state (host_state),
      .resume_det (bus_resume_det),
      .disc_det   (bus_disc_det),
      .core_req   (core_req)
   );

   assign hw_req[DOM_DEV]  = 1'b0;
   assign hw_req[DOM_HOST] = core_req;
   assign hw_req[DOM_BUS]  = |dma_req;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      usb_clk_domain_ctl #(
         .STS_STAGES (STS_STAGES)
      ) i_dom (
         .clk     (clk),
         .rst_n   (rst_n),
         .sw_en   (sw_clk_en[d]),
         .hw_req  (hw_req[d]),
         .clk_run (dom_clk_run[d]),
         .clk_on  (clk_on_sts[d])
      );
   end

   assign usb_need_clk = (|sw_clk_en) | (|hw_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= chip_pwr_down & usb_int_en & usb_need_clk;
   end

   assign wake_req          = wake_q;
   assign dev_dma_clk_req   = dma_req[DMA_DEV];
   assign host_dma_clk_req  = dma_req[DMA_HOST];
   assign host_core_clk_req = core_req;

   // R8
   need_covers_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dom_clk_run) |-> usb_need_clk);

   // R7
   bus_run_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_dma_clk_req || host_dma_clk_req) |-> dom_clk_run[DOM_BUS]);

   // R7
   host_run_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_core_clk_req |-> dom_clk_run[DOM_HOST]);

   // R10
   wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(usb_need_clk) && $past(chip_pwr_down)));

endmodule

// File: tb/test_usb_clkreq_mgr.sv
module test_usb_clkreq_mgr;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       dev_dma_stb, host_dma_stb;
   logic [1:0] host_state;
   logic       bus_resume_det, bus_disc_det, frame_tick;
   logic [2:0] sw_clk_en;
   logic       usb_int_en, chip_pwr_down;
   logic       dev_dma_clk_req, host_dma_clk_req, host_core_clk_req;
   logic [2:0] dom_clk_run;
   logic       usb_need_clk;
   logic [2:0] clk_on_sts;
   logic       wake_req;

   always #5 clk = ~clk;

   usb_clkreq_mgr i_usb_clkreq_mgr (
      .clk               (clk),
      .rst_n             (rst_n),
      .dev_dma_stb       (dev_dma_stb),
      .host_dma_stb      (host_dma_stb),
      .host_state        (host_state),
      .bus_resume_det    (bus_resume_det),
      .bus_disc_det      (bus_disc_det),
      .frame_tick        (frame_tick),
      .sw_clk_en         (sw_clk_en),
      .usb_int_en        (usb_int_en),
      .chip_pwr_down     (chip_pwr_down),
      .dev_dma_clk_req   (dev_dma_clk_req),
      .host_dma_clk_req  (host_dma_clk_req),
      .host_core_clk_req (host_core_clk_req),
      .dom_clk_run       (dom_clk_run),
      .usb_need_clk      (usb_need_clk),
      .clk_on_sts        (clk_on_sts),
      .wake_req          (wake_req)
   );

   typedef struct {
      int         due;
      int         sel;
      logic [2:0] val;
      string      tag;
   } exp_item_t;

   exp_item_t sbq[$];
   exp_item_t keepq[$];
   int        cyc = 0;
   int        n_tests = 0;
   int        n_fail = 0;
   bit        done = 1'b0;

   localparam int O_DEVREQ = 0, O_HSTREQ = 1, O_CORE = 2, O_RUN = 3,
                  O_NEED = 4, O_STS = 5, O_WAKE = 6;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [2:0] obs(int sel);
      case (sel)
         O_DEVREQ: return {2'b00, dev_dma_clk_req};
         O_HSTREQ: return {2'b00, host_dma_clk_req};
         O_CORE:   return {2'b00, host_core_clk_req};
         O_RUN:    return dom_clk_run;
         O_NEED:   return {2'b00, usb_need_clk};
         O_STS:    return clk_on_sts;
         default:  return {2'b00, wake_req};
      endcase
   endfunction

   task automatic expect_at(int sel, logic [2:0] val, string tag, int dly);
      exp_item_t it;
      it.due = cyc + dly;
      it.sel = sel;
      it.val = val;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   // monitor: compare due items shortly after each falling edge
   always @(negedge clk) begin
      #2;
      keepq = {};
      foreach (sbq[i]) begin
         if (sbq[i].due == cyc) begin
            n_tests++;
            if (obs(sbq[i].sel) !== sbq[i].val) begin
               n_fail++;
               $display("FAIL %s: output %0d actual %b expected %b (cycle %0d)",
                        sbq[i].tag, sbq[i].sel, obs(sbq[i].sel), sbq[i].val, cyc);
            end
         end else if (sbq[i].due < cyc) begin
            n_tests++;
            n_fail++;
            $display("FAIL %s: output %0d missed, actual %b expected %b",
                     sbq[i].tag, sbq[i].sel, obs(sbq[i].sel), sbq[i].val);
         end else begin
            keepq.push_back(sbq[i]);
         end
      end
      sbq = keepq;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      dev_dma_stb = 1'b0; host_dma_stb = 1'b0;
      host_state = 2'd3; bus_resume_det = 1'b0; bus_disc_det = 1'b0;
      frame_tick = 1'b0; sw_clk_en = 3'b000;
      usb_int_en = 1'b0; chip_pwr_down = 1'b0;

      // R1 reset state
      nxt(); nxt();
      expect_at(O_DEVREQ, 3'd0, "R1", 0);
      expect_at(O_HSTREQ, 3'd0, "R1", 0);
      expect_at(O_CORE,   3'd0, "R1", 0);
      expect_at(O_RUN,    3'd0, "R1", 0);
      expect_at(O_NEED,   3'd0, "R1", 0);
      expect_at(O_STS,    3'd0, "R1", 0);
      expect_at(O_WAKE,   3'd0, "R1", 0);
      nxt(); rst_n = 1'b1;

      // R2 immediate device request, R3 hold over two ticks
      nxt(); dev_dma_stb = 1'b1;
      expect_at(O_DEVREQ, 3'd1, "R2", 0);
      expect_at(O_HSTREQ, 3'd0, "R2", 0);
      expect_at(O_RUN, 3'b100, "R7", 0);
      expect_at(O_NEED, 3'd1, "R8", 0);
      nxt(); dev_dma_stb = 1'b0;
      expect_at(O_DEVREQ, 3'd1, "R3", 0);
      expect_at(O_STS, 3'b100, "R9", 0);
      nxt(); frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd1, "R3", 1);
      nxt(); frame_tick = 1'b0;
      nxt(); nxt();
      expect_at(O_DEVREQ, 3'd1, "R3", 0);
      nxt(); frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd1, "R3", 0);
      expect_at(O_DEVREQ, 3'd0, "R3", 1);
      expect_at(O_NEED, 3'd0, "R8", 1);
      expect_at(O_RUN, 3'd0, "R7", 1);
      nxt(); frame_tick = 1'b0;
      expect_at(O_STS, 3'b100, "R9", 0);
      nxt();
      expect_at(O_STS, 3'b000, "R9", 0);

      // R4 retrigger restarts the hold
      nxt(); dev_dma_stb = 1'b1;
      nxt(); dev_dma_stb = 1'b0; frame_tick = 1'b1;
      nxt(); frame_tick = 1'b0; dev_dma_stb = 1'b1;
      nxt(); dev_dma_stb = 1'b0; frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd1, "R4", 1);
      nxt(); frame_tick = 1'b0;
      nxt(); frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd0, "R4", 1);
      nxt(); frame_tick = 1'b0;

      // R3 strobe coinciding with a tick reloads
      nxt(); dev_dma_stb = 1'b1; frame_tick = 1'b1;
      nxt(); dev_dma_stb = 1'b0; frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd1, "R3", 1);
      nxt(); frame_tick = 1'b1;
      expect_at(O_DEVREQ, 3'd0, "R3", 1);
      nxt(); frame_tick = 1'b0;

      // R2 host engine independent
      nxt(); host_dma_stb = 1'b1;
      expect_at(O_HSTREQ, 3'd1, "R2", 0);
      expect_at(O_DEVREQ, 3'd0, "R2", 0);
      nxt(); host_dma_stb = 1'b0;
      expect_at(O_HSTREQ, 3'd1, "R2", 0);
      expect_at(O_DEVREQ, 3'd0, "R2", 0);
      nxt(); frame_tick = 1'b1;
      nxt(); frame_tick = 1'b1;
      expect_at(O_HSTREQ, 3'd0, "R3", 1);
      nxt(); frame_tick = 1'b0;

      // R5 host core request outside suspend
      nxt(); host_state = 2'd2;
      expect_at(O_CORE, 3'd1, "R5", 0);
      expect_at(O_RUN, 3'b010, "R7", 0);
      expect_at(O_NEED, 3'd1, "R8", 0);
      nxt(); host_state = 2'd0;
      expect_at(O_CORE, 3'd1, "R5", 0);
      nxt(); host_state = 2'd1;
      expect_at(O_CORE, 3'd1, "R5", 0);

      // R6 suspend with and without bus events
      nxt(); host_state = 2'd3;
      expect_at(O_CORE, 3'd0, "R6", 0);
      expect_at(O_NEED, 3'd0, "R8", 0);
      nxt(); bus_resume_det = 1'b1;
      expect_at(O_CORE, 3'd1, "R6", 0);
      nxt(); bus_resume_det = 1'b0; bus_disc_det = 1'b1;
      expect_at(O_CORE, 3'd1, "R6", 0);
      nxt(); bus_disc_det = 1'b0;
      expect_at(O_CORE, 3'd0, "R6", 0);

      // R7 software enables, R9 status latency
      nxt(); sw_clk_en = 3'b001;
      expect_at(O_RUN, 3'b001, "R7", 0);
      expect_at(O_NEED, 3'd1, "R8", 0);
      expect_at(O_STS, 3'b000, "R9", 0);
      expect_at(O_STS, 3'b001, "R9", 1);
      nxt(); sw_clk_en = 3'b100; host_dma_stb = 1'b1;
      expect_at(O_RUN, 3'b100, "R7", 0);
      nxt(); sw_clk_en = 3'b000; host_dma_stb = 1'b0;
      expect_at(O_RUN, 3'b100, "R7", 0);
      nxt(); frame_tick = 1'b1;
      nxt(); frame_tick = 1'b1;
      expect_at(O_RUN, 3'b000, "R7", 1);
      nxt(); frame_tick = 1'b0;

      // R10 wake request
      nxt(); chip_pwr_down = 1'b1; usb_int_en = 1'b0; sw_clk_en = 3'b010;
      expect_at(O_WAKE, 3'd0, "R10", 1);
      nxt(); usb_int_en = 1'b1;
      expect_at(O_WAKE, 3'd1, "R10", 1);
      nxt(); sw_clk_en = 3'b000;
      expect_at(O_WAKE, 3'd0, "R10", 1);
      nxt(); sw_clk_en = 3'b010; chip_pwr_down = 1'b0;
      expect_at(O_WAKE, 3'd0, "R10", 1);
      nxt(); sw_clk_en = 3'b000; usb_int_en = 1'b0;

      nxt(); nxt(); nxt();
      #3;
      n_tests++;
      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL drain: actual %0d pending expected 0", sbq.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule